// File: doc/BRIEF.md
# Write-Only Two-Wire Command Receiver

This block is a target on a two-wire serial bus (I2C, up to 400 kbit/s) that only accepts writes. Both bus lines are brought onto the system clock through two flip-flops each and edge-detected there. A transfer opens with a START condition and a 7-bit address byte. Only a matching address with the direction bit clear is acknowledged. Every later byte in the transfer is either a control byte or a payload byte.

A control byte carries two flags. The continue flag says whether exactly one payload byte follows before the next control byte, or whether every byte up to the end of the transfer is payload. The route flag says whether the payload goes to the instruction path or to the display-memory write path. Each payload byte comes out as a one-cycle strobe, together with the byte and a kind bit. The memory side keeps its own write pointer and advances it on each data strobe.

The block never returns data. Its only output on the bus is the acknowledge, driven on a separate pull-down output. Reads and foreign addresses get no acknowledge, and the block then stays silent until the next START.

Top module: `i2c_wr_slave`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `sda_ack_o` and `byte_vld_o` are 0.
- R2: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. A STOP releases `sda_ack_o` and discards a partly shifted byte, so no strobe results from it.
- R3: The first byte after a START is taken MSB first. Bits 7:1 are compared with `SLAVE_ADDR`, and bit 0 is the direction (0 = write). On a match with bit 0 = 0, that byte is acknowledged.
- R4: An address byte that does not match, or has bit 0 = 1, is not acknowledged. No further byte is acknowledged or strobed until the next START.
- R5: The byte after an accepted address is a control byte. Bit 7 is the continue flag and bit 6 is the route flag. It is acknowledged and produces no strobe.
- R6: With the continue flag at 1, exactly one payload byte follows, and the byte after that is again a control byte.
- R7: With the continue flag at 0, every byte up to the next STOP or START is payload of the same kind, even when its value has bit 7 set.
- R8: Each payload byte raises `byte_vld_o` for exactly one cycle, with the byte on `byte_o`. `byte_kind_o` is 0 for the instruction path (route flag 0) and 1 for the memory-data path (route flag 1).
- R9: Inside an accepted transfer, every byte is acknowledged. `sda_ack_o` rises after the SCL fall that ends the 8th bit, stays steady while SCL is high, and drops after the SCL fall that ends the 9th clock.
- R10: A repeated START in the middle of a transfer returns the parser to the address phase, whatever routing was active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line, asynchronous |
| sda_i | input | 1 | Serial data line as seen on the bus, asynchronous |
| sda_ack_o | output | 1 | 1 = pull SDA low (acknowledge) |
| byte_o | output | 8 | Payload byte, valid with `byte_vld_o` |
| byte_vld_o | output | 1 | One-cycle strobe per payload byte |
| byte_kind_o | output | 1 | 0 = instruction, 1 = memory data; valid with `byte_vld_o` |

## Verification
Two events can land in the same cycle: a START or STOP being detected, and the byte shifter acting on an SCL edge or on a routing mode left over from an earlier byte. Whenever a bus condition is seen, it must take priority. The bench provokes this with a repeated START issued right after a run of data bytes, and with a STOP issued halfway through a byte. It then judges the outcome from the strobe log: the byte after the restart must be treated as an address, no strobe may come from the cut-off byte, and the next transfer must be routed only by its own control byte.

// File: rtl/i2c_wr_pkg.sv
package i2c_wr_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 7;
    localparam int BIT_CW = $clog2(BYTE_W);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RECV,
        ST_ACKWAIT,
        ST_ACKHOLD,
        ST_IGNORE
    } link_state_e;

    typedef enum logic [1:0] {
        PH_ADDR,
        PH_CTRL,
        PH_PAYLOAD
    } byte_phase_e;

    typedef enum logic {
        KIND_CMD  = 1'b0,
        KIND_DATA = 1'b1
    } byte_kind_e;

    typedef struct packed {
        logic cont;
        logic sel;
    } ctrl_t;

    function automatic ctrl_t decode_ctrl(input logic [BYTE_W-1:0] b);
        ctrl_t c;
        c.cont = b[7];
        c.sel  = b[6];
        return c;
    endfunction

    function automatic logic addr_hit(input logic [BYTE_W-1:0] b,
                                      input logic [ADDR_W-1:0] a);
        return (b[BYTE_W-1:1] == a) && !b[0];
    endfunction

endpackage

// File: rtl/i2c_wr_sync.sv
module i2c_wr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    localparam int PW = STAGES + 1;

    logic [PW-1:0] scl_pipe;
    logic [PW-1:0] sda_pipe;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[PW-2:0], scl_i};
            sda_pipe <= {sda_pipe[PW-2:0], sda_i};
        end
    end

    logic scl_now, scl_prev, sda_now, sda_prev;
    assign scl_now  = scl_pipe[STAGES-1];
    assign scl_prev = scl_pipe[STAGES];
    assign sda_now  = sda_pipe[STAGES-1];
    assign sda_prev = sda_pipe[STAGES];

    assign scl_o      = scl_now;
    assign scl_rise_o = scl_now & ~scl_prev;
    assign scl_fall_o = ~scl_now & scl_prev;
    assign start_o    = scl_now & scl_prev & sda_prev & ~sda_now;
    assign stop_o     = scl_now & scl_prev & ~sda_prev & sda_now;

endmodule

// File: rtl/i2c_wr_core.sv
module i2c_wr_core
    import i2c_wr_pkg::*;
#(
    parameter logic [ADDR_W-1:0] SLAVE_ADDR = 7'h3C
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_lvl,
    input  logic              sda_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    output logic              ack_o,
    output logic [BYTE_W-1:0] byte_o,
    output logic              byte_vld_o,
    output logic              byte_kind_o
);
    link_state_e       state;
    byte_phase_e       phase;
    logic [BIT_CW-1:0] bitcnt;
    logic [BYTE_W-1:0] shreg;
    logic              ack_q;
    logic              cont_q;
    byte_kind_e        kind_q;
    logic [BYTE_W-1:0] out_q;
    logic              vld_q;

    logic [BYTE_W-1:0] full_byte;
    ctrl_t             ctl;
    logic              last_bit;

    assign full_byte = {shreg[BYTE_W-2:0], sda_lvl};
    assign ctl       = decode_ctrl(full_byte);
    assign last_bit  = (bitcnt == BIT_CW'(BYTE_W - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            phase  <= PH_ADDR;
            bitcnt <= '0;
            shreg  <= '0;
            ack_q  <= 1'b0;
            cont_q <= 1'b0;
            kind_q <= KIND_CMD;
            out_q  <= '0;
            vld_q  <= 1'b0;
        end else begin
            vld_q <= 1'b0;
            if (start_det) begin
                state  <= ST_RECV;
                phase  <= PH_ADDR;
                bitcnt <= '0;
                ack_q  <= 1'b0;
            end else if (stop_det) begin
                state  <= ST_IDLE;
                ack_q  <= 1'b0;
            end else begin
                unique case (state)
                    ST_RECV: if (scl_rise) begin
                        shreg  <= full_byte;
                        bitcnt <= bitcnt + 1'b1;
                        if (last_bit) begin
                            unique case (phase)
                                PH_ADDR: begin
                                    if (addr_hit(full_byte, SLAVE_ADDR)) begin
                                        phase <= PH_CTRL;
                                        state <= ST_ACKWAIT;
                                    end else begin
                                        state <= ST_IGNORE;
                                    end
                                end
                                PH_CTRL: begin
                                    cont_q <= ctl.cont;
                                    kind_q <= ctl.sel ? KIND_DATA : KIND_CMD;
                                    phase  <= PH_PAYLOAD;
                                    state  <= ST_ACKWAIT;
                                end
                                default: begin
                                    out_q <= full_byte;
                                    vld_q <= 1'b1;
                                    if (cont_q) phase <= PH_CTRL;
                                    state <= ST_ACKWAIT;
                                end
                            endcase
                        end
                    end
                    ST_ACKWAIT: if (scl_fall) begin
                        ack_q <= 1'b1;
                        state <= ST_ACKHOLD;
                    end
                    ST_ACKHOLD: if (scl_fall) begin
                        ack_q  <= 1'b0;
                        bitcnt <= '0;
                        state  <= ST_RECV;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign ack_o       = ack_q;
    assign byte_o      = out_q;
    assign byte_vld_o  = vld_q;
    assign byte_kind_o = kind_q;

    // R8: strobe lasts a single cycle
    assert_strobe_single_R8: assert property (@(posedge clk) disable iff (rst)
        vld_q |=> !vld_q);

    // R4: an ignored transfer never acknowledges
    assert_silent_when_ignored_R4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IGNORE) |-> !ack_q);

    // R9: acknowledge does not move while SCL stays high
    assert_ack_steady_scl_high_R9: assert property (@(posedge clk) disable iff (rst)
        (scl_lvl && $past(scl_lvl) && !$past(start_det) && !$past(stop_det))
            |-> $stable(ack_q));

    // R9: strobe comes before the acknowledge is driven
    assert_strobe_before_ack_R9: assert property (@(posedge clk) disable iff (rst)
        vld_q |-> !ack_q);

    // R2: STOP releases the line
    assert_stop_releases_R2: assert property (@(posedge clk) disable iff (rst)
        stop_det |=> !ack_q);

endmodule

// File: rtl/i2c_wr_slave.sv
module i2c_wr_slave
    import i2c_wr_pkg::*;
#(
    parameter logic [ADDR_W-1:0] SLAVE_ADDR  = 7'h3C,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_ack_o,
    output logic [BYTE_W-1:0] byte_o,
    output logic              byte_vld_o,
    output logic              byte_kind_o
);
    logic scl_lvl, scl_rise, scl_fall, start_det, stop_det, sda_lvl;

    i2c_wr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst        (rst),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_o      (scl_lvl),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_det),
        .stop_o     (stop_det)
    );

    logic [SYNC_STAGES-1:0] sda_chain;
    always_ff @(posedge clk) begin
        if (rst) sda_chain <= '1;
        else     sda_chain <= {sda_chain[SYNC_STAGES-2:0], sda_i};
    end
    assign sda_lvl = sda_chain[SYNC_STAGES-1];

    i2c_wr_core #(.SLAVE_ADDR(SLAVE_ADDR)) u_core (
        .clk         (clk),
        .rst         (rst),
        .scl_lvl     (scl_lvl),
        .sda_lvl     (sda_lvl),
        .scl_rise    (scl_rise),
        .scl_fall    (scl_fall),
        .start_det   (start_det),
        .stop_det    (stop_det),
        .ack_o       (sda_ack_o),
        .byte_o      (byte_o),
        .byte_vld_o  (byte_vld_o),
        .byte_kind_o (byte_kind_o)
    );

endmodule

// File: tb/i2c_wr_slave_test.sv
module i2c_wr_slave_test;
    localparam int H = 8;
    localparam logic [6:0] ADR = 7'h3C;
    localparam logic [7:0] WADR = {ADR, 1'b0};

    // {control byte, payload byte, expected kind}
    localparam logic [16:0] VEC [6] = '{
        {8'h80, 8'h01, 1'b0},
        {8'hC0, 8'h41, 1'b1},
        {8'h00, 8'hA5, 1'b0},
        {8'h40, 8'h5A, 1'b1},
        {8'h80, 8'hFF, 1'b0},
        {8'hC0, 8'h00, 1'b1}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_ack_o, byte_vld_o, byte_kind_o;
    logic [7:0] byte_o;
    logic sda_bus;

    int tests = 0;
    int fails = 0;
    int log_n = 0;
    logic [7:0] log_b [64];
    logic       log_k [64];

    always #10 clk = ~clk;

    assign sda_bus = m_sda & ~sda_ack_o;

    i2c_wr_slave #(.SLAVE_ADDR(ADR)) uut (
        .clk         (clk),
        .rst         (rst),
        .scl_i       (m_scl),
        .sda_i       (sda_bus),
        .sda_ack_o   (sda_ack_o),
        .byte_o      (byte_o),
        .byte_vld_o  (byte_vld_o),
        .byte_kind_o (byte_kind_o)
    );

    always @(negedge clk) begin
        if (byte_vld_o && log_n < 64) begin
            log_b[log_n] = byte_o;
            log_k[log_n] = byte_kind_o;
            log_n = log_n + 1;
        end
    end

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wt(H);
        m_scl = 1'b1; wt(H);
        m_sda = 1'b0; wt(H);
        m_scl = 1'b0; wt(H);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wt(H);
        m_scl = 1'b1; wt(H);
        m_sda = 1'b1; wt(H);
    endtask

    task automatic send_bit(input logic b);
        m_sda = b;    wt(H);
        m_scl = 1'b1; wt(H);
        m_scl = 1'b0; wt(H);
    endtask

    task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string tag);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        m_sda = 1'b1; wt(H);
        m_scl = 1'b1; wt(H / 2);
        chk(sda_bus == !exp_ack, tag, int'(!sda_bus), int'(exp_ack));
        wt(H / 2);
        m_scl = 1'b0; wt(H);
    endtask

    task automatic chk_log(input int idx, input logic [7:0] b, input logic k, input string tag);
        chk(log_b[idx] == b, tag, int'(log_b[idx]), int'(b));
        chk(log_k[idx] == k, tag, int'(log_k[idx]), int'(k));
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: reset state
        wt(4);
        chk(sda_ack_o == 1'b0, "R1 ack in reset", int'(sda_ack_o), 0);
        chk(byte_vld_o == 1'b0, "R1 strobe in reset", int'(byte_vld_o), 0);
        rst = 1'b0;
        wt(1);
        chk(sda_ack_o == 1'b0 && byte_vld_o == 1'b0, "R1 after reset",
            int'({sda_ack_o, byte_vld_o}), 0);
        wt(H);

        // R8 R5: table of single control/payload transfers
        for (int v = 0; v < 6; v++) begin
            log_n = 0;
            bus_start();
            send_byte(WADR, 1'b1, "R3 address ack");
            send_byte(VEC[v][16:9], 1'b1, "R5 control ack");
            send_byte(VEC[v][8:1], 1'b1, "R9 payload ack");
            bus_stop();
            wt(H);
            chk(log_n == 1, "R8 strobe count", log_n, 1);
            chk_log(0, VEC[v][8:1], VEC[v][0], "R8 routed byte");
        end

        // R4: foreign address
        log_n = 0;
        bus_start();
        send_byte({7'h3D, 1'b0}, 1'b0, "R4 foreign address nack");
        send_byte(8'h40, 1'b0, "R4 ignored control");
        send_byte(8'h11, 1'b0, "R4 ignored payload");
        bus_stop();
        wt(H);
        chk(log_n == 0, "R4 no strobe after mismatch", log_n, 0);

        // R4: read direction
        bus_start();
        send_byte({ADR, 1'b1}, 1'b0, "R4 read nack");
        send_byte(8'h40, 1'b0, "R4 read ignored");
        bus_stop();
        wt(H);
        chk(log_n == 0, "R4 no strobe after read", log_n, 0);

        // R6 R7: continue pairs then a run
        log_n = 0;
        bus_start();
        send_byte(WADR, 1'b1, "R3 address ack");
        send_byte(8'h80, 1'b1, "R5 ctrl ack");
        send_byte(8'h11, 1'b1, "R9 ack");
        send_byte(8'hC0, 1'b1, "R6 ctrl after pair");
        send_byte(8'h22, 1'b1, "R9 ack");
        send_byte(8'h40, 1'b1, "R6 ctrl after pair");
        send_byte(8'hC0, 1'b1, "R7 run byte ack");
        send_byte(8'h33, 1'b1, "R7 run byte ack");
        bus_stop();
        wt(H);
        chk(log_n == 4, "R6 strobe count", log_n, 4);
        chk_log(0, 8'h11, 1'b0, "R6 first pair cmd");
        chk_log(1, 8'h22, 1'b1, "R6 second pair data");
        chk_log(2, 8'hC0, 1'b1, "R7 control-like value is payload");
        chk_log(3, 8'h33, 1'b1, "R7 run continues");

        // R10: repeated start during a data run
        log_n = 0;
        bus_start();
        send_byte(WADR, 1'b1, "R3 address ack");
        send_byte(8'h40, 1'b1, "R5 ctrl ack");
        send_byte(8'h55, 1'b1, "R9 ack");
        bus_start();
        send_byte(WADR, 1'b1, "R10 address after restart");
        send_byte(8'h00, 1'b1, "R10 ctrl after restart");
        send_byte(8'h01, 1'b1, "R9 ack");
        send_byte(8'h38, 1'b1, "R9 ack");
        bus_stop();
        wt(H);
        chk(log_n == 3, "R10 strobe count", log_n, 3);
        chk_log(0, 8'h55, 1'b1, "R10 before restart");
        chk_log(1, 8'h01, 1'b0, "R10 after restart cmd");
        chk_log(2, 8'h38, 1'b0, "R10 run after restart");

        // R2: stop in the middle of a payload byte
        log_n = 0;
        bus_start();
        send_byte(WADR, 1'b1, "R3 address ack");
        send_byte(8'h40, 1'b1, "R5 ctrl ack");
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        m_scl = 1'b0; wt(H);
        bus_stop();
        wt(H);
        chk(log_n == 0, "R2 partial byte dropped", log_n, 0);
        chk(sda_ack_o == 1'b0, "R2 line released", int'(sda_ack_o), 0);
        bus_start();
        send_byte(WADR, 1'b1, "R2 fresh transfer address");
        send_byte(8'h80, 1'b1, "R5 ctrl ack");
        send_byte(8'h66, 1'b1, "R9 ack");
        bus_stop();
        wt(H);
        chk(log_n == 1, "R2 fresh transfer strobe", log_n, 1);
        chk_log(0, 8'h66, 1'b0, "R2 fresh transfer routing");

        finish_run();
    end

endmodule